// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock waveform and the data strobes for an I2C master. A byte engine sits above it and hands it one phase request at a time: a START on an idle bus, one data or acknowledge bit, a repeated START, or a STOP. The generator pulls SCL and SDA low or releases them, and tells the byte engine when to drive the next data level and when to sample the line. It also reports the end of each phase. An acknowledge bit is an ordinary bit phase: the engine asks for a 0 to acknowledge, or for a 1 to release SDA and read the target's answer.

The timing comes from four counts in system-clock cycles, each set on its own: the full SCL period, the SCL low time, the setup time around START and STOP, and the data setup ahead of the SCL rising edge. The usual settings are:

- period = input clock / bus rate, with a bus rate of 100 kHz by default and never above 400 kHz;
- low time and START/STOP setup = half the period;
- data setup = one sixteenth of the period.

The high-phase counter advances only while the SCL readback is high. A target that stretches the clock therefore pauses the bit without shortening it. Between phases SCL is parked low. After a STOP both lines are left released.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset SCL and SDA are both released (`scl_drive_low`=0, `sda_drive_low`=0) and `req_ready` is 1.
- R2: A count of zero in any configuration input behaves exactly as a count of one.
- R3: In a bit phase SCL is held low for exactly eff(low) cycles, where eff(x) is x, or 1 when x is 0.
- R4: After SCL is released, a bit phase lasts eff(period)−eff(low) cycles of SCL readback high (1 if that difference is not positive). Cycles in which the readback stays low (stretching) add to the phase but not to that count.
- R5: In a bit phase `drive_strobe` pulses once, min(eff(data_setup), eff(low)) cycles before the first released SCL cycle. From the next cycle `sda_drive_low` equals the inverse of the requested bit.
- R6: In a bit phase `sample_strobe` pulses once, in the high cycle with index floor(H/2) (counting from 0), where H is the high count of R4. `sample_bit` then holds the SDA readback of that cycle. SDA does not change while SCL is high in a bit phase.
- R7: START (`req_kind`=0) pulls SDA low with SCL released for eff(setup) cycles and then parks SCL low.
- R8: STOP (`req_kind`=3) holds SDA low through eff(low) SCL-low cycles and eff(setup) SCL-high cycles. It then releases SDA and leaves SCL released.
- R9: A repeated START (`req_kind`=2) releases SDA during eff(low) SCL-low cycles. It then keeps SCL high for eff(setup) cycles with SDA high, followed by eff(setup) cycles with SDA low, and then parks SCL low.
- R10: `phase_done` pulses for one cycle on the last cycle of each phase. `req_ready` is 1 on the following cycle. A bit phase (`req_kind`=1) ends with SCL parked low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CW | SCL period in system cycles |
| cfg_low | input | CW | SCL low time in system cycles |
| cfg_edge_setup | input | CW | Setup time for START, repeated START and STOP |
| cfg_data_setup | input | CW | SDA setup ahead of SCL release |
| req_valid | input | 1 | Phase request, accepted when `req_ready` is 1 |
| req_kind | input | 2 | 0 START, 1 bit, 2 repeated START, 3 STOP |
| req_bit | input | 1 | Bit level for a bit phase |
| req_ready | output | 1 | Idle and able to accept a phase |
| scl_in | input | 1 | SCL line readback |
| sda_in | input | 1 | SDA line readback |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| drive_strobe | output | 1 | Point at which SDA takes the new bit |
| sample_strobe | output | 1 | Point at which SDA is sampled |
| sample_bit | output | 1 | Last sampled SDA level |
| phase_done | output | 1 | Last cycle of the current phase |

## Verification
Bit phases are run under three count sets:

- A mid-range set, where the drive point falls inside the low phase and the sample point sits in the middle of the high phase.
- A set whose data setup exceeds the low time, which shows the clamp of the drive point to the start of the low phase.
- A set whose low time exceeds the period, which shows the clamp of the high time to one cycle.

An all-zero set separates the treatment of zero as one from a counter that wraps. A stretched bit shows that the high count waits for the readback and does not run on the released drive. A target pulling SDA low during a released bit shows that the sample comes from the line and not from the driven level. The START, repeated START and STOP phases are told apart by the number of cycles each line spends low.

// File: rtl/i2c_scl_pkg.sv
`timescale 1ns/1ps
package i2c_scl_pkg;
  typedef enum logic [1:0] {
    PH_START   = 2'd0,
    PH_BIT     = 2'd1,
    PH_RESTART = 2'd2,
    PH_STOP    = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_HOLD = 2'd3
  } state_e;
endpackage

// File: rtl/i2c_scl_calc.sv
`timescale 1ns/1ps
module i2c_scl_calc #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_edge_setup,
  input  logic [CW-1:0] cfg_data_setup,
  output logic [CW-1:0] low_len,
  output logic [CW-1:0] high_len,
  output logic [CW-1:0] setup_len,
  output logic [CW-1:0] drive_idx,
  output logic [CW-1:0] sample_idx
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  // zero is read as one so that no counter can stall
  function automatic logic [CW-1:0] eff(input logic [CW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  // high time is what remains of the period, at least one cycle
  function automatic logic [CW-1:0] high_of(input logic [CW-1:0] p, input logic [CW-1:0] l);
    return (p > l) ? (p - l) : ONE;
  endfunction

  // low-phase index at which the new bit goes out
  function automatic logic [CW-1:0] drive_of(input logic [CW-1:0] l, input logic [CW-1:0] d);
    return (l > d) ? (l - d) : '0;
  endfunction

  logic [CW-1:0] period_len, dsu_len;

  always_comb begin
    period_len = eff(cfg_period);
    low_len    = eff(cfg_low);
    setup_len  = eff(cfg_edge_setup);
    dsu_len    = eff(cfg_data_setup);
    high_len   = high_of(period_len, low_len);
    drive_idx  = drive_of(low_len, dsu_len);
    sample_idx = high_len >> 1;
  end
endmodule

// File: rtl/i2c_scl_cnt.sv
`timescale 1ns/1ps
module i2c_scl_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          last
);
  assign last = en && (count == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (en)   count <= last ? '0 : count + 1'b1;
  end

  // R2: a limit of at least one keeps the count inside its window
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (count < limit));
endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_edge_setup,
  input  logic [CW-1:0] cfg_data_setup,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_bit,
  output logic          req_ready,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  output logic          drive_strobe,
  output logic          sample_strobe,
  output logic          sample_bit,
  output logic          phase_done
);
  import i2c_scl_pkg::*;

  logic [CW-1:0] low_len, high_len, setup_len, drive_idx, sample_idx;
  logic [CW-1:0] cnt_val, cnt_limit;
  logic          cnt_clr, cnt_en, cnt_last;
  state_e        state;
  phase_e        kind;
  logic          bit_q, park_q, sda_q, smp_q;
  logic          accept;

  i2c_scl_calc #(.CW(CW)) u_calc (
    .cfg_period(cfg_period), .cfg_low(cfg_low),
    .cfg_edge_setup(cfg_edge_setup), .cfg_data_setup(cfg_data_setup),
    .low_len(low_len), .high_len(high_len), .setup_len(setup_len),
    .drive_idx(drive_idx), .sample_idx(sample_idx)
  );

  i2c_scl_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .limit(cnt_limit), .count(cnt_val), .last(cnt_last)
  );

  // counter steering per state
  always_comb begin
    cnt_clr   = (state == ST_IDLE);
    cnt_en    = 1'b0;
    cnt_limit = low_len;
    unique case (state)
      ST_LOW:  begin cnt_en = 1'b1;   cnt_limit = low_len; end
      ST_HIGH: begin cnt_en = scl_in; cnt_limit = (kind == PH_BIT) ? high_len : setup_len; end
      ST_HOLD: begin cnt_en = 1'b1;   cnt_limit = setup_len; end
      default: begin cnt_en = 1'b0;   cnt_limit = low_len; end
    endcase
  end

  // named events
  assign accept        = req_valid && (state == ST_IDLE);
  assign drive_strobe  = (state == ST_LOW) && (kind == PH_BIT) && (cnt_val == drive_idx);
  assign sample_strobe = (state == ST_HIGH) && (kind == PH_BIT) && scl_in && (cnt_val == sample_idx);
  assign phase_done    = ((state == ST_HIGH) && cnt_last && (kind != PH_RESTART))
                      || ((state == ST_HOLD) && cnt_last);

  assign req_ready     = (state == ST_IDLE);
  assign scl_drive_low = (state == ST_LOW) || ((state == ST_IDLE) && park_q);
  assign sda_drive_low = sda_q;
  assign sample_bit    = smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= PH_START;
      bit_q  <= 1'b1;
      park_q <= 1'b0;
      sda_q  <= 1'b0;
      smp_q  <= 1'b1;
    end else begin
      if (sample_strobe) smp_q <= sda_in;
      unique case (state)
        ST_IDLE: if (accept) begin
          kind  <= phase_e'(req_kind);
          bit_q <= req_bit;
          unique case (phase_e'(req_kind))
            PH_START:   begin state <= ST_HOLD; sda_q <= 1'b1; end
            PH_BIT:     state <= ST_LOW;
            PH_RESTART: begin state <= ST_LOW;  sda_q <= 1'b0; end
            default:    begin state <= ST_LOW;  sda_q <= 1'b1; end
          endcase
        end
        ST_LOW: begin
          if (drive_strobe) sda_q <= ~bit_q;
          if (cnt_last)     state <= ST_HIGH;
        end
        ST_HIGH: if (cnt_last) begin
          unique case (kind)
            PH_RESTART: begin state <= ST_HOLD; sda_q <= 1'b1; end
            PH_STOP:    begin state <= ST_IDLE; sda_q <= 1'b0; park_q <= 1'b0; end
            default:    begin state <= ST_IDLE; park_q <= 1'b1; end
          endcase
        end
        default: if (cnt_last) begin
          state  <= ST_IDLE;
          park_q <= 1'b1;
        end
      endcase
    end
  end

  // R5/R6: drive and sample points never coincide
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_strobe, sample_strobe}));
  // R4: a stretched clock freezes the high count
  assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && !scl_in) |=> $stable(cnt_val));
  // R6: data stays put while SCL is high in a bit phase
  assert_sda_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && kind == PH_BIT) |=> $stable(sda_drive_low));
  // R10: the end of a phase is followed by readiness
  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> req_ready);
  // R8: both lines released after STOP
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && kind == PH_STOP) |=> (!scl_drive_low && !sda_drive_low));
endmodule

// File: tb/i2c_scl_timer_bench.sv
`timescale 1ns/1ps
module i2c_scl_timer_bench;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_edge_setup = '0, cfg_data_setup = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic req_bit = 1'b0;
  logic req_ready, scl_in, sda_in, scl_drive_low, sda_drive_low;
  logic drive_strobe, sample_strobe, sample_bit, phase_done;

  int stretch_len = 0;
  int stretch_cnt = 0;
  logic tgt_low = 1'b0;

  assign scl_in = !scl_drive_low && (stretch_cnt == 0);
  assign sda_in = !sda_drive_low && !tgt_low;

  always @(posedge clk) begin
    if (scl_drive_low) stretch_cnt <= stretch_len;
    else if (stretch_cnt > 0) stretch_cnt <= stretch_cnt - 1;
  end

  i2c_scl_timer #(.CW(CW)) u_i2c_scl_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_low(cfg_low),
    .cfg_edge_setup(cfg_edge_setup), .cfg_data_setup(cfg_data_setup),
    .req_valid(req_valid), .req_kind(req_kind), .req_bit(req_bit),
    .req_ready(req_ready), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .drive_strobe(drive_strobe), .sample_strobe(sample_strobe),
    .sample_bit(sample_bit), .phase_done(phase_done)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-phase observations
  int n_low, n_high, n_sda, n_tot, ds_at, rel_at, smp_hi, sda_end;
  // bench copy of the count rules
  int e_low, e_high, e_su, e_ds;

  function automatic int eff_of(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_cfg(input int p, input int l, input int s, input int d);
    @(negedge clk);
    cfg_period = CW'(p); cfg_low = CW'(l); cfg_edge_setup = CW'(s); cfg_data_setup = CW'(d);
    e_low  = eff_of(l);
    e_su   = eff_of(s);
    e_high = (eff_of(p) > e_low) ? eff_of(p) - e_low : 1;
    e_ds   = (eff_of(d) < e_low) ? eff_of(d) : e_low;
  endtask

  task automatic run_phase(input logic [1:0] k, input logic b);
    bit fin = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_bit = b;
    @(posedge clk);
    #1 req_valid = 1'b0;
    n_low = 0; n_high = 0; n_sda = 0; n_tot = 0;
    ds_at = -1; rel_at = -1; smp_hi = -1; sda_end = 0;
    while (!fin && n_tot < 5000) begin
      @(negedge clk);
      if (scl_drive_low) n_low++;
      else if (rel_at < 0) rel_at = n_tot;
      if (sample_strobe) smp_hi = n_high;
      if (scl_in) n_high++;
      if (sda_drive_low) n_sda++;
      if (drive_strobe) ds_at = n_tot;
      sda_end = int'(sda_drive_low);
      fin = phase_done;
      n_tot++;
    end
    check(fin, "phase_done seen", n_tot, 0);
  endtask

  task automatic bit_phase(input logic b, input int stretch, input logic tlow, input string tag);
    stretch_len = stretch;
    tgt_low = tlow;
    run_phase(2'd1, b);
    check(n_low == e_low, {tag, " R3 low cycles"}, n_low, e_low);
    check(n_high == e_high, {tag, " R4 high cycles"}, n_high, e_high);
    check(n_tot == e_low + stretch + e_high, {tag, " R4 total with stretch"}, n_tot, e_low + stretch + e_high);
    check(rel_at - ds_at == e_ds, {tag, " R5 drive lead"}, rel_at - ds_at, e_ds);
    check(sda_end == int'(!b), {tag, " R5 sda level"}, sda_end, int'(!b));
    check(smp_hi == e_high / 2, {tag, " R6 sample index"}, smp_hi, e_high / 2);
    @(negedge clk);
    check(sample_bit == (b && !tlow), {tag, " R6 sampled bit"}, int'(sample_bit), int'(b && !tlow));
    check(req_ready && scl_drive_low, {tag, " R10 ready, SCL parked"}, int'(req_ready && scl_drive_low), 1);
    stretch_len = 0;
    tgt_low = 1'b0;
  endtask

  task automatic start_phase(input string tag);
    run_phase(2'd0, 1'b0);
    check(n_low == 0, {tag, " R7 SCL stays released"}, n_low, 0);
    check(n_sda == e_su, {tag, " R7 SDA low cycles"}, n_sda, e_su);
    @(negedge clk);
    check(scl_drive_low && req_ready, {tag, " R7 SCL parked"}, int'(scl_drive_low), 1);
  endtask

  task automatic stop_phase(input string tag);
    run_phase(2'd3, 1'b0);
    check(n_low == e_low, {tag, " R8 low cycles"}, n_low, e_low);
    check(n_high == e_su, {tag, " R8 high cycles"}, n_high, e_su);
    check(n_sda == e_low + e_su, {tag, " R8 SDA low cycles"}, n_sda, e_low + e_su);
    @(negedge clk);
    check(!scl_drive_low && !sda_drive_low, {tag, " R8 lines released"},
          int'(scl_drive_low) + int'(sda_drive_low), 0);
  endtask

  task automatic restart_phase(input string tag);
    run_phase(2'd2, 1'b0);
    check(n_low == e_low, {tag, " R9 low cycles"}, n_low, e_low);
    check(n_high == 2 * e_su, {tag, " R9 high cycles"}, n_high, 2 * e_su);
    check(n_sda == e_su, {tag, " R9 SDA low cycles"}, n_sda, e_su);
    @(negedge clk);
    check(scl_drive_low && req_ready, {tag, " R9 SCL parked"}, int'(scl_drive_low), 1);
  endtask

  task automatic reset_test();
    @(negedge clk);
    check(!scl_drive_low, "R1 SCL released", int'(scl_drive_low), 0);
    check(!sda_drive_low, "R1 SDA released", int'(sda_drive_low), 0);
    check(req_ready, "R1 ready", int'(req_ready), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_cfg(20, 10, 10, 3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    reset_test();
    start_phase("midA");
    bit_phase(1'b1, 0, 1'b0, "midA b1");
    bit_phase(1'b0, 0, 1'b0, "midA b0");
    bit_phase(1'b1, 5, 1'b0, "midA stretch");
    bit_phase(1'b1, 0, 1'b1, "midA ack-read");
    restart_phase("midA");
    bit_phase(1'b0, 0, 1'b0, "midA after rs");
    stop_phase("midA");
    set_cfg(12, 8, 6, 12);
    start_phase("dsB");
    bit_phase(1'b0, 0, 1'b0, "dsB clamp");
    bit_phase(1'b1, 2, 1'b0, "dsB stretch");
    stop_phase("dsB");
    set_cfg(5, 9, 3, 2);
    start_phase("hiC");
    bit_phase(1'b1, 0, 1'b0, "hiC high clamp");
    stop_phase("hiC");
    set_cfg(0, 0, 0, 0);
    start_phase("R2 zero");
    bit_phase(1'b1, 0, 1'b0, "R2 zero");
    restart_phase("R2 zero");
    bit_phase(1'b0, 1, 1'b0, "R2 zero st");
    stop_phase("R2 zero");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule